// File: doc/BRIEF.md
# Bus Load-Reserve Reservation Monitor

This block sits beside a shared local bus and watches every transfer that any master sends to any slave on that bus. For each master that can make atomic reservations it keeps a single reservation: a valid flag and the granule address that was reserved. Load-reserve transfers create or replace a reservation. Stores from other agents to a reserved granule destroy it. A store-conditional consumes the reservation of the master that issues it.

A store-conditional gets its answer within the cycle in which it is presented. The block raises `sc_ok` when the issuing master still holds a reservation for the same granule. Otherwise it raises `wr_inhibit`, which tells the slaves not to perform the write. A master learns that it lost its reservation only through this response. No separate cancel signal exists. Addresses are compared at granule resolution, and the granule size is a parameter (4 bytes by default). Bus IDs at or above `N_MASTERS` belong to agents that can store but cannot reserve.

Top module: `resv_monitor`

## Requirements
- R1: After the synchronous active-low reset, no master holds a reservation, so every store-conditional fails until a new load-reserve is made.
- R2: A load-reserve (kind 2) from master m sets m's reservation to the granule of its address. A later store-conditional from m to any byte of that granule passes, because address bits below the granule size are ignored.
- R3: A second load-reserve from master m replaces the first. A store-conditional to the old granule then fails, and one to the new granule passes.
- R4: A store-conditional (kind 3) from master m clears m's reservation whether it passes or fails, so an immediately repeated store-conditional fails.
- R5: A plain store (kind 1) from master m leaves m's own reservation intact, even when it targets the reserved granule.
- R6: A plain store from any other master, or from a non-reserving agent, to a reserved granule clears that reservation. A store to a different granule leaves it intact.
- R7: During a valid store-conditional, exactly one of `sc_ok` and `wr_inhibit` is high in that same cycle. `wr_inhibit` is high when the issuer's reservation is absent or holds a different granule.
- R8: A passing store-conditional counts as a write and clears other masters' reservations on that granule. A failing one writes nothing and clears no other master's reservation.
- R9: A store-conditional from an ID of `N_MASTERS` or above always fails with `wr_inhibit` high.
- R10: Transfer kinds are encoded as 0 load, 1 store, 2 load-reserve and 3 store-conditional. With `bus_vld` low the transfer is ignored, and `sc_ok` and `wr_inhibit` are both low whenever no valid store-conditional is present.
- R11: One transfer is handled per clock, and its effect on the reservations is visible to the transfer presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_vld | input | 1 | A transfer is present this cycle |
| bus_mid | input | MID_W | ID of the issuing master or agent |
| bus_addr | input | ADDR_W | Byte address of the transfer |
| bus_kind | input | 2 | Transfer kind (0 load, 1 store, 2 load-reserve, 3 store-conditional) |
| sc_ok | output | 1 | Store-conditional succeeds this cycle |
| wr_inhibit | output | 1 | Store-conditional fails; slaves must not write |

## Verification
The assertions assume that at most one transfer is on the bus per cycle and that `bus_kind`, `bus_mid` and `bus_addr` are stable and defined whenever `bus_vld` is high. The bench drives exactly one transfer, or an idle cycle, per clock, and it changes all inputs together at the falling edge. The directed sequences cover the corner cases: replacement, own stores, foreign stores to the same and to a different granule, and failing versus passing store-conditionals. A long random phase then uses few masters and a very small address space, so that granule collisions between masters happen often.

// File: rtl/resv_pkg.sv
// Shared transfer-kind encoding for the reservation monitor.
// Assumes bus_kind is a 2-bit field decoded identically by all agents.
package resv_pkg;
    typedef enum logic [1:0] {
        XK_LOAD  = 2'd0,
        XK_STORE = 2'd1,
        XK_LDRSV = 2'd2,
        XK_STCND = 2'd3
    } xfer_kind_e;
endpackage

// File: rtl/resv_slot.sv
// One reservation register: a valid flag plus the reserved granule.
// Assumes set and clr come from the decoder; set has priority because a
// single transfer never asks the same slot for both.
module resv_slot #(
    parameter int GW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic          clr,
    input  logic [GW-1:0] set_gran,
    output logic          vld_q,
    output logic [GW-1:0] gran_q
);
    // Update the reservation flag and granule on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            gran_q <= '0;
        end else if (set) begin
            vld_q  <= 1'b1;
            gran_q <= set_gran;
        end else if (clr) begin
            vld_q  <= 1'b0;
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !vld_q);
    // R2
    set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (vld_q && gran_q == $past(set_gran)));
    // R4
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !vld_q);
endmodule

// File: rtl/resv_decode.sv
// Combinational decode of one bus transfer against all held reservations.
// Produces per-slot set/clear requests and the store-conditional verdict.
// Assumes IDs at or above N_MASTERS cannot reserve.
module resv_decode
    import resv_pkg::*;
#(
    parameter int N_MASTERS = 3,
    parameter int MID_W     = 2,
    parameter int GW        = 14
) (
    input  logic                    bus_vld,
    input  logic [MID_W-1:0]        bus_mid,
    input  logic [GW-1:0]           bus_gran,
    input  logic [1:0]              bus_kind,
    input  logic [N_MASTERS-1:0]    hold_vld,
    input  logic [N_MASTERS-1:0][GW-1:0] hold_gran,
    output logic [N_MASTERS-1:0]    set_vec,
    output logic [N_MASTERS-1:0]    clr_vec,
    output logic                    sc_ok,
    output logic                    wr_inhibit
);
    logic [N_MASTERS-1:0] own;
    logic [N_MASTERS-1:0] hit;
    logic is_sc, is_st, is_lr, sc_match, writes;

    // Classify the transfer kind.
    always_comb begin
        is_sc = bus_vld && (xfer_kind_e'(bus_kind) == XK_STCND);
        is_st = bus_vld && (xfer_kind_e'(bus_kind) == XK_STORE);
        is_lr = bus_vld && (xfer_kind_e'(bus_kind) == XK_LDRSV);
    end

    // Find the issuer's slot and every slot that holds the addressed granule.
    always_comb begin
        sc_match = 1'b0;
        for (int m = 0; m < N_MASTERS; m++) begin
            own[m] = (bus_mid == MID_W'(m));
            hit[m] = hold_vld[m] && (hold_gran[m] == bus_gran);
            sc_match = sc_match | (own[m] & hit[m]);
        end
    end

    // Derive the verdict and the set/clear requests.
    always_comb begin
        sc_ok      = is_sc && sc_match;
        wr_inhibit = is_sc && !sc_match;
        writes     = is_st || sc_ok;
        for (int m = 0; m < N_MASTERS; m++) begin
            set_vec[m] = is_lr && own[m];
            clr_vec[m] = (is_sc && own[m]) || (writes && !own[m] && hit[m]);
        end
    end
endmodule

// File: rtl/resv_monitor.sv
// Reservation monitor for a single-level shared bus. Snoops every
// transfer, holds one reservation per capable master and answers each
// store-conditional in the cycle it is presented.
// Assumes one transfer per clock and inputs stable while bus_vld is high.
module resv_monitor
    import resv_pkg::*;
#(
    parameter int N_MASTERS  = 3,
    parameter int MID_W      = 2,
    parameter int ADDR_W     = 16,
    parameter int GRAN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic [MID_W-1:0]  bus_mid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    output logic              sc_ok,
    output logic              wr_inhibit
);
    localparam int GLSB = $clog2(GRAN_BYTES);
    localparam int GW   = ADDR_W - GLSB;

    logic [GW-1:0]                 bus_gran;
    logic [N_MASTERS-1:0]          hold_vld;
    logic [N_MASTERS-1:0][GW-1:0]  hold_gran;
    logic [N_MASTERS-1:0]          set_vec;
    logic [N_MASTERS-1:0]          clr_vec;

    // Drop the byte offset inside a granule.
    assign bus_gran = bus_addr[ADDR_W-1:GLSB];

    resv_decode #(.N_MASTERS(N_MASTERS), .MID_W(MID_W), .GW(GW)) u_dec (
        .bus_vld    (bus_vld),
        .bus_mid    (bus_mid),
        .bus_gran   (bus_gran),
        .bus_kind   (bus_kind),
        .hold_vld   (hold_vld),
        .hold_gran  (hold_gran),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .sc_ok      (sc_ok),
        .wr_inhibit (wr_inhibit)
    );

    for (genvar m = 0; m < N_MASTERS; m++) begin : g_slot
        resv_slot #(.GW(GW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set      (set_vec[m]),
            .clr      (clr_vec[m]),
            .set_gran (bus_gran),
            .vld_q    (hold_vld[m]),
            .gran_q   (hold_gran[m])
        );

        // R5
        own_store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_vld && bus_kind == 2'd1 && bus_mid == MID_W'(m))
            |=> (hold_vld[m] == $past(hold_vld[m])));
    end

    // R7
    sc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_kind == 2'd3) |-> $countones({sc_ok, wr_inhibit}) == 1);
    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_vld && bus_kind == 2'd3) |-> !(sc_ok || wr_inhibit));
    // R9
    nocap_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_kind == 2'd3 && int'(bus_mid) >= N_MASTERS) |-> wr_inhibit);
endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
    localparam int NM = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic [1:0]  bus_mid = '0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_kind = '0;
    logic        sc_ok, wr_inhibit;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit ref_v [NM];
    int ref_g [NM];

    always #10 clk = ~clk;

    resv_monitor #(.N_MASTERS(NM), .MID_W(2), .ADDR_W(16), .GRAN_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_mid(bus_mid),
        .bus_addr(bus_addr), .bus_kind(bus_kind),
        .sc_ok(sc_ok), .wr_inhibit(wr_inhibit)
    );

    task automatic cmp(string tag, string sig, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // One bus cycle: drive, compare against model, then advance the model.
    task automatic xfer(bit v, int mid, int addr, int kind, string tag);
        bit cap, sc, pass, writes;
        int g;
        @(negedge clk);
        bus_vld = v; bus_mid = mid[1:0]; bus_addr = addr[15:0]; bus_kind = kind[1:0];
        #5;
        cap  = (mid < NM);
        g    = addr >> 2;
        sc   = v && kind == 3;
        pass = sc && cap && ref_v[mid] && ref_g[mid] == g;
        cmp(tag, "sc_ok", sc_ok, pass);
        cmp(tag, "wr_inhibit", wr_inhibit, sc && !pass);
        @(posedge clk);
        #1;
        if (v) begin
            writes = (kind == 1) || (kind == 3 && pass);
            for (int m = 0; m < NM; m++)
                if (writes && m != mid && ref_v[m] && ref_g[m] == g) ref_v[m] = 0;
            if (cap && kind == 3) ref_v[mid] = 0;
            if (cap && kind == 2) begin ref_v[mid] = 1; ref_g[mid] = g; end
        end
    endtask

    initial begin
        for (int m = 0; m < NM; m++) begin ref_v[m] = 0; ref_g[m] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: idle and non-SC transfers keep both outputs low
        xfer(0, 0, 0, 3, "R10 idle");
        xfer(1, 1, 'h40, 0, "R10 load");
        // R1: nothing reserved after reset
        for (int m = 0; m < NM; m++) xfer(1, m, 'h40, 3, "R1 sc after reset");
        // R2: set then pass with different byte offset
        xfer(1, 0, 'h40, 2, "R2 lr");
        xfer(1, 0, 'h43, 3, "R2 sc pass");
        // R4: repeat fails
        xfer(1, 0, 'h40, 3, "R4 sc repeat");
        // R3: replacement
        xfer(1, 1, 'h80, 2, "R3 lr old");
        xfer(1, 1, 'h100, 2, "R3 lr new");
        xfer(1, 1, 'h80, 3, "R3 sc old fails");
        xfer(1, 1, 'h100, 2, "R3 lr again");
        xfer(1, 1, 'h100, 3, "R3 sc new passes");
        // R5: own store keeps reservation
        xfer(1, 2, 'h20, 2, "R5 lr");
        xfer(1, 2, 'h20, 1, "R5 own store");
        xfer(1, 2, 'h20, 3, "R5 sc pass");
        // R6: foreign stores
        xfer(1, 0, 'h60, 2, "R6 lr");
        xfer(1, 1, 'h64, 1, "R6 store other granule");
        xfer(1, 0, 'h60, 3, "R6 sc pass");
        xfer(1, 0, 'h60, 2, "R6 lr");
        xfer(1, 3, 'h61, 1, "R6 agent store same granule");
        xfer(1, 0, 'h60, 3, "R6 sc fail");
        // R7: address mismatch fails
        xfer(1, 1, 'h10, 2, "R7 lr");
        xfer(1, 1, 'h14, 3, "R7 sc mismatch");
        // R8: failing SC clears nobody, passing SC clears others
        xfer(1, 0, 'h30, 2, "R8 lr m0");
        xfer(1, 1, 'h30, 2, "R8 lr m1");
        xfer(1, 2, 'h30, 3, "R8 sc m2 fails");
        xfer(1, 1, 'h30, 3, "R8 sc m1 passes");
        xfer(1, 0, 'h30, 3, "R8 sc m0 lost");
        // R9: non-capable agent
        xfer(1, 3, 'h30, 3, "R9 agent sc");
        // R10: invalid transfer ignored
        xfer(1, 0, 'h50, 2, "R10 lr");
        xfer(0, 1, 'h50, 1, "R10 invalid store");
        xfer(0, 0, 'h50, 3, "R10 invalid sc");
        xfer(1, 0, 'h50, 3, "R10 sc pass");
        // R11: back-to-back random traffic over a tiny address space
        for (int i = 0; i < 4000; i++)
            xfer(($urandom % 8) != 0, $urandom % 4, $urandom % 16, $urandom % 4, "R11 random");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule